// File: doc/BRIEF.md
# SPI Memory Command Decoder

This block is the serial front end of a byte-addressed nonvolatile memory that also carries a small register space beside the main array. It acts as an SPI mode 0 target. It takes the first byte after chip select falls as a command byte and sorts it into one of three kinds:

- commands that carry nothing but the command byte;
- commands that move a single status byte;
- commands that carry an address and then a run of data bytes.

For the third kind, one address and data sequencer serves both the memory array and the register space. The command byte alone decides which strobe ports the sequencer drives.

A write-enable latch gates every write. The block samples the serial pins with its own system clock, so the serial clock must stay in each level for at least SYNC_STAGES+6 system clock cycles. The array, the register contents and any protection logic sit outside the block. Read data must be valid on the cycle after a read strobe, and it must stay valid while `xfer_addr` holds.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, `status` is 0x00, `so_oe` is 0 and no strobe is active.
- R2: Command 0x06 sets the write-enable latch. The latch always appears as bit 1 of `status`.
- R3: When chip select rises at the end of a command whose command byte was 0x04, 0x01, 0x02 or 0x12, the latch clears to 0.
- R4: No other command byte changes the latch. This includes 0x03, 0x05, 0x13 and unknown codes.
- R5: Command 0x01 loads the data byte into every status bit except bit 1, but only when the latch was 1 at the start of the command. Bit 1 keeps the latch value whatever the byte holds. When the latch was 0, `status` does not change.
- R6: Command 0x05 shifts `status` out MSB first on every following byte. `so_oe` stays 0 while the command byte is received.
- R7: Command 0x03 takes a 16-bit address, MSB byte first. It pulses `mem_rd` at that address and shifts the returned bytes out MSB first. The address increments after each byte, and the carry runs into the upper byte.
- R8: Command 0x02 takes a 16-bit address. With the latch set at command start, it pulses `mem_wr` once per complete data byte, at incrementing addresses. With the latch clear, no strobe is produced.
- R9: Commands 0x13 and 0x12 take one address byte. They strobe `cmp_rd` and `cmp_wr` in the same way, and the address wraps within 8 bits.
- R10: During command-byte-only commands and unknown codes, `so_oe` stays 0 and no strobe occurs. After chip select rises, `so_oe` returns to 0.
- R11: A data byte that chip select cuts short is dropped and is never written.
- R12: At most one strobe is active in any cycle, and a write strobe occurs only while the latch is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so`; 0 means the pin floats |
| status | output | 8 | Status register; bit 1 is the write-enable latch |
| mem_rd | output | 1 | One-cycle read strobe to the memory array |
| mem_wr | output | 1 | One-cycle write strobe to the memory array |
| cmp_rd | output | 1 | One-cycle read strobe to the register space |
| cmp_wr | output | 1 | One-cycle write strobe to the register space |
| xfer_addr | output | ADDR_W | Address that goes with any strobe |
| xfer_wdata | output | 8 | Data that goes with a write strobe |
| mem_rdata | input | 8 | Memory read data, sampled one cycle after `mem_rd` |
| cmp_rdata | input | 8 | Register read data, sampled one cycle after `cmp_rd` |

## Verification
The assertions check the latch on every cycle. It may rise only after a 0x06 command byte and fall only on a chip-select rise. A status write must leave it alone. The strobes must stay exclusive, writes must never occur with the latch clear, and the output enable must drop after deselect.

Only the bench scenarios can show the serial data itself. That covers the status byte shifted out MSB first, the address increment that carries across a byte boundary, the wrap inside the register space, and the exact address and data of each write. They also show that a cut-short byte never reaches the array.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   localparam logic [7:0] OPC_SET_WE  = 8'h06;
   localparam logic [7:0] OPC_CLR_WE  = 8'h04;
   localparam logic [7:0] OPC_STAT_RD = 8'h05;
   localparam logic [7:0] OPC_STAT_WR = 8'h01;
   localparam logic [7:0] OPC_MEM_RD  = 8'h03;
   localparam logic [7:0] OPC_MEM_WR  = 8'h02;
   localparam logic [7:0] OPC_CMP_RD  = 8'h13;
   localparam logic [7:0] OPC_CMP_WR  = 8'h12;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OPC,
      PH_STAT_OUT,
      PH_STAT_IN,
      PH_ADDR,
      PH_DATA,
      PH_SKIP
   } phase_t;

   // command bytes whose completion arms the latch clear at deselect
   function automatic logic arms_we_clear(input logic [7:0] opc);
      return (opc == OPC_CLR_WE) || (opc == OPC_STAT_WR) ||
             (opc == OPC_MEM_WR) || (opc == OPC_CMP_WR);
   endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);

   logic [STAGES-1:0][W-1:0] chain;

   initial begin : p_param_chk
      if (STAGES < 2) $fatal(1, "spi_cmd_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {STAGES{RST_VAL}};
         q_prev <= RST_VAL;
      end else begin
         chain  <= {chain[STAGES-2:0], d};
         q_prev <= chain[STAGES-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       smp,
   input  logic       bit_in,
   output logic       byte_vld,
   output logic [7:0] byte_q
);

   logic [6:0] sr;
   logic [2:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr       <= '0;
         cnt      <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (clr) begin
            cnt <= '0;
         end else if (smp) begin
            sr  <= {sr[5:0], bit_in};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
               byte_vld <= 1'b1;
               byte_q   <= {sr, bit_in};
            end
         end
      end
   end

endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] load_val,
   input  logic       shift,
   output logic       so
);

   logic [7:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
         so <= 1'b0;
      end else if (load) begin
         sr <= load_val;
      end else if (shift) begin
         so <= sr[7];
         sr <= {sr[6:0], 1'b0};
      end
   end

endmodule

// File: rtl/spi_cmd_wel.sv
module spi_cmd_wel
   import spi_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_fall,
   input  logic       cs_rise,
   input  logic       opc_vld,
   input  logic [7:0] opc,
   output logic       wel
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel   <= 1'b0;
         armed <= 1'b0;
      end else if (cs_fall) begin
         armed <= 1'b0;
      end else if (cs_rise) begin
         if (armed) wel <= 1'b0;
         armed <= 1'b0;
      end else if (opc_vld) begin
         if (opc == OPC_SET_WE) wel <= 1'b1;
         if (arms_we_clear(opc)) armed <= 1'b1;
      end
   end

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int CADDR_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int WE_BIT      = 1,
   parameter bit STAT_REPEAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   output logic              so,
   output logic              so_oe,
   output logic [7:0]        status,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              cmp_rd,
   output logic              cmp_wr,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [7:0]        xfer_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic [7:0]        cmp_rdata
);

   localparam int MEM_ABYTES = ADDR_W / 8;
   localparam int CMP_ABYTES = CADDR_W / 8;
   localparam int CNT_W      = $clog2(MEM_ABYTES + 1);
   localparam logic [ADDR_W-1:0] CMP_MASK = ADDR_W'((64'd1 << CADDR_W) - 64'd1);
   localparam logic [7:0]        WE_MASK  = 8'(1) << WE_BIT;

   initial begin : p_param_chk
      if (ADDR_W % 8 != 0 || ADDR_W < 8 || ADDR_W > 32)
         $fatal(1, "spi_cmd_decoder: ADDR_W must be 8..32 and a multiple of 8");
      if (CADDR_W % 8 != 0 || CADDR_W < 8 || CADDR_W > ADDR_W)
         $fatal(1, "spi_cmd_decoder: CADDR_W must be a multiple of 8 within ADDR_W");
      if (WE_BIT < 0 || WE_BIT > 7)
         $fatal(1, "spi_cmd_decoder: WE_BIT must address a status bit");
   end

   // ---------------- pin sampling and edge detection
   logic [2:0] pin_q, pin_prev;
   logic       cs_act, cs_fall, cs_rise, sck_rise, sck_fall;

   spi_cmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(pin_q), .q_prev(pin_prev)
   );

   assign cs_act   = !pin_q[2];
   assign cs_fall  =  pin_prev[2] && !pin_q[2];
   assign cs_rise  = !pin_prev[2] &&  pin_q[2];
   assign sck_rise = !pin_prev[1] &&  pin_q[1];
   assign sck_fall =  pin_prev[1] && !pin_q[1];

   // ---------------- byte receiver
   logic       byte_vld;
   logic [7:0] rx_byte;

   spi_cmd_rx i_rx (
      .clk(clk), .rst_n(rst_n), .clr(cs_fall), .smp(sck_rise && cs_act),
      .bit_in(pin_q[0]), .byte_vld(byte_vld), .byte_q(rx_byte)
   );

   // ---------------- command state
   phase_t            phase;
   logic              is_comp, is_write, wr_ok;
   logic              rd_pend, ld_pend;
   logic [CNT_W-1:0]  abytes;
   logic [ADDR_W-1:0] addr_q, amask, addr_inc;
   logic [7:0]        stat_q;
   logic              opc_vld, stat_wr_evt, stat_reload, ld_stat, tx_load;
   logic [7:0]        tx_val;
   logic              wel;

   assign opc_vld     = byte_vld && cs_act && (phase == PH_OPC);
   assign stat_wr_evt = byte_vld && cs_act && (phase == PH_STAT_IN);
   assign amask       = is_comp ? CMP_MASK : '1;
   assign addr_inc    = (addr_q + ADDR_W'(1)) & amask;

   spi_cmd_wel i_wel (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .opc_vld(opc_vld), .opc(rx_byte), .wel(wel)
   );

   // status byte: stored bits with the latch merged in at WE_BIT
   assign status = stat_q | (wel ? WE_MASK : 8'h00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    stat_q <= '0;
      else if (stat_wr_evt && wr_ok) stat_q <= rx_byte & ~WE_MASK;
   end

   // variant: status repeats on every byte, or only the first byte carries it
   generate
      if (STAT_REPEAT) begin : g_stat_repeat
         assign stat_reload = byte_vld && cs_act && (phase == PH_STAT_OUT);
      end else begin : g_stat_once
         assign stat_reload = 1'b0;
      end
   endgenerate

   assign ld_stat = (opc_vld && rx_byte == OPC_STAT_RD) || stat_reload;
   assign tx_load = ld_stat || ld_pend;
   assign tx_val  = ld_stat ? status : (is_comp ? cmp_rdata : mem_rdata);

   spi_cmd_tx i_tx (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(tx_val),
      .shift(sck_fall && cs_act), .so(so)
   );

   assign so_oe = cs_act &&
                  ((phase == PH_STAT_OUT) || (phase == PH_DATA && !is_write));

   // ---------------- command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         is_comp    <= 1'b0;
         is_write   <= 1'b0;
         wr_ok      <= 1'b0;
         rd_pend    <= 1'b0;
         ld_pend    <= 1'b0;
         abytes     <= '0;
         addr_q     <= '0;
         mem_rd     <= 1'b0;
         mem_wr     <= 1'b0;
         cmp_rd     <= 1'b0;
         cmp_wr     <= 1'b0;
         xfer_addr  <= '0;
         xfer_wdata <= '0;
      end else begin
         mem_rd  <= 1'b0;
         mem_wr  <= 1'b0;
         cmp_rd  <= 1'b0;
         cmp_wr  <= 1'b0;
         rd_pend <= 1'b0;
         ld_pend <= mem_rd || cmp_rd;
         if (rd_pend && !cs_rise) begin
            if (is_comp) cmp_rd <= 1'b1;
            else         mem_rd <= 1'b1;
            xfer_addr <= addr_q;
         end
         if (cs_rise) begin
            phase   <= PH_IDLE;
            ld_pend <= 1'b0;
         end else if (cs_fall) begin
            phase <= PH_OPC;
         end else if (byte_vld && cs_act) begin
            unique case (phase)
               PH_OPC: begin
                  wr_ok  <= wel;
                  addr_q <= '0;
                  case (rx_byte)
                     OPC_STAT_RD: phase <= PH_STAT_OUT;
                     OPC_STAT_WR: phase <= PH_STAT_IN;
                     OPC_MEM_RD, OPC_MEM_WR, OPC_CMP_RD, OPC_CMP_WR: begin
                        // within the four address commands, bit 4 picks the
                        // register space and a clear bit 0 marks a write
                        phase    <= PH_ADDR;
                        is_comp  <= rx_byte[4];
                        is_write <= !rx_byte[0];
                        abytes   <= rx_byte[4] ? CNT_W'(CMP_ABYTES) : CNT_W'(MEM_ABYTES);
                     end
                     default: phase <= PH_SKIP;
                  endcase
               end
               PH_STAT_IN: phase <= PH_SKIP;
               PH_ADDR: begin
                  addr_q <= ((addr_q << 8) | ADDR_W'(rx_byte)) & amask;
                  abytes <= abytes - CNT_W'(1);
                  if (abytes == CNT_W'(1)) begin
                     phase <= PH_DATA;
                     if (!is_write) rd_pend <= 1'b1;
                  end
               end
               PH_DATA: begin
                  addr_q <= addr_inc;
                  if (is_write) begin
                     if (wr_ok) begin
                        if (is_comp) cmp_wr <= 1'b1;
                        else         mem_wr <= 1'b1;
                        xfer_addr  <= addr_q;
                        xfer_wdata <= rx_byte;
                     end
                  end else begin
                     rd_pend <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wel,
   input logic       opc_vld,
   input logic [7:0] opc,
   input logic       cs_rise,
   input logic       stat_wr_evt,
   input logic       so_oe,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       cmp_rd,
   input logic       cmp_wr
);

   assert_we_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(opc_vld && opc == 8'h06));

   assert_we_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wel) |-> $past(cs_rise));

   assert_stat_keeps_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr_evt |=> $stable(wel));

   assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, cmp_rd, cmp_wr}));

   assert_write_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || cmp_wr) |-> wel);

   assert_hiz_after_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !so_oe);

endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk i_chk (
   .clk(clk), .rst_n(rst_n), .wel(wel), .opc_vld(opc_vld), .opc(rx_byte),
   .cs_rise(cs_rise), .stat_wr_evt(stat_wr_evt), .so_oe(so_oe),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .cmp_rd(cmp_rd), .cmp_wr(cmp_wr)
);

// File: tb/test_spi_cmd_decoder.sv
`timescale 1ns/1ps
module test_spi_cmd_decoder;

   localparam int HALF = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic so, so_oe, mem_rd, mem_wr, cmp_rd, cmp_wr;
   logic [7:0]  status, xfer_wdata, mem_rdata, cmp_rdata;
   logic [15:0] xfer_addr;

   always #2 clk = ~clk;

   spi_cmd_decoder i_spi_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
      .so_oe(so_oe), .status(status), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .cmp_rd(cmp_rd), .cmp_wr(cmp_wr), .xfer_addr(xfer_addr),
      .xfer_wdata(xfer_wdata), .mem_rdata(mem_rdata), .cmp_rdata(cmp_rdata)
   );

   // bench memory models: fixed patterns of the address
   function automatic logic [7:0] fm(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction
   assign mem_rdata = fm(xfer_addr);
   assign cmp_rdata = ~xfer_addr[7:0];

   // strobe logs
   int nmw = 0, nmr = 0, ncw = 0, ncr = 0;
   logic [15:0] mw_a [0:63];
   logic [7:0]  mw_d [0:63];
   logic [15:0] mr_a [0:63];
   logic [15:0] cw_a [0:63];
   logic [7:0]  cw_d [0:63];
   logic [15:0] cr_a [0:63];

   always @(posedge clk) begin
      if (mem_wr && nmw < 64) begin mw_a[nmw] <= xfer_addr; mw_d[nmw] <= xfer_wdata; nmw <= nmw + 1; end
      if (mem_rd && nmr < 64) begin mr_a[nmr] <= xfer_addr; nmr <= nmr + 1; end
      if (cmp_wr && ncw < 64) begin cw_a[ncw] <= xfer_addr; cw_d[ncw] <= xfer_wdata; ncw <= ncw + 1; end
      if (cmp_rd && ncr < 64) begin cr_a[ncr] <= xfer_addr; ncr <= ncr + 1; end
   end

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   logic [7:0] txb [0:15];
   logic [7:0] rxb [0:15];
   int oe_op, oe_any;
   logic [7:0] st_pre;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input int nb, input int tail);
      oe_op = 0; oe_any = 0;
      @(negedge clk); cs_n = 1'b0;
      wait_clk(HALF);
      for (int b = 0; b < nb; b++) begin
         for (int i = 7; i >= 0; i--) begin
            si = txb[b][i];
            wait_clk(HALF);
            rxb[b][i] = so;
            if (so_oe && b == 0) oe_op++;
            if (so_oe) oe_any++;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
         end
      end
      for (int i = 0; i < tail; i++) begin
         si = 1'b1;
         wait_clk(HALF);
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
      wait_clk(HALF);
      st_pre = status;
      cs_n = 1'b1;
      wait_clk(12);
   endtask

   task automatic cmd1(input logic [7:0] op);
      txb[0] = op;
      frame(1, 0);
   endtask

   task automatic t_reset;
      chk("R1 status after reset", status, 8'h00);
      chk("R1 so_oe after reset", so_oe, 1'b0);
      chk("R1 no strobes", {mem_rd, mem_wr, cmp_rd, cmp_wr}, 4'b0);
   endtask

   task automatic t_set_clear;
      cmd1(8'h06);
      chk("R2 latch set by 0x06", status, 8'h02);
      chk("R10 no output enable on 0x06", oe_any, 0);
      cmd1(8'h04);
      chk("R3 latch cleared by 0x04", status, 8'h00);
      chk("R10 no output enable on 0x04", oe_any, 0);
   endtask

   task automatic t_keep_latch;
      cmd1(8'h06);
      txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00; frame(4, 0);
      chk("R4 latch kept after 0x03", status, 8'h02);
      txb[0] = 8'h05; txb[1] = 8'h00; frame(2, 0);
      chk("R4 latch kept after 0x05", status, 8'h02);
      txb[0] = 8'h13; txb[1] = 8'h00; txb[2] = 8'h00; frame(3, 0);
      chk("R4 latch kept after 0x13", status, 8'h02);
      cmd1(8'h77);
      chk("R4 latch kept after unknown code", status, 8'h02);
   endtask

   task automatic t_stat_write;
      txb[0] = 8'h01; txb[1] = 8'hA5; frame(2, 0);
      chk("R5 status during enabled write keeps latch", st_pre, 8'hA7);
      chk("R5 status after enabled write", status, 8'hA5);
      txb[0] = 8'h01; txb[1] = 8'h3C; frame(2, 0);
      chk("R5 write ignored with latch clear", status, 8'hA5);
      cmd1(8'h06);
      txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; frame(3, 0);
      chk("R6 first status byte out", rxb[1], 8'hA7);
      chk("R6 repeated status byte out", rxb[2], 8'hA7);
      chk("R6 no output enable in command byte", oe_op, 0);
      txb[0] = 8'h01; txb[1] = 8'hFF; frame(2, 0);
      chk("R5 bit 1 not loaded from data", status, 8'hFD);
      cmd1(8'h06);
      txb[0] = 8'h01; txb[1] = 8'h00; frame(2, 0);
      chk("R3 latch cleared after 0x01", status, 8'h00);
   endtask

   task automatic t_mem_write;
      int b0;
      cmd1(8'h06);
      b0 = nmw;
      txb[0] = 8'h02; txb[1] = 8'h12; txb[2] = 8'h34;
      txb[3] = 8'hAA; txb[4] = 8'hBB; txb[5] = 8'hCC;
      frame(6, 0);
      chk("R8 write count", nmw - b0, 3);
      chk("R8 write addr 0", mw_a[b0], 16'h1234);
      chk("R8 write data 0", mw_d[b0], 8'hAA);
      chk("R8 write addr 2", mw_a[b0+2], 16'h1236);
      chk("R8 write data 2", mw_d[b0+2], 8'hCC);
      chk("R3 latch cleared after 0x02", status, 8'h00);
      b0 = nmw;
      txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h05; txb[3] = 8'h77;
      frame(4, 0);
      chk("R8 no write with latch clear", nmw - b0, 0);
   endtask

   task automatic t_partial;
      int b0;
      cmd1(8'h06);
      b0 = nmw;
      txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h10; txb[3] = 8'h11;
      frame(4, 5);
      chk("R11 only complete byte written", nmw - b0, 1);
      chk("R11 complete byte addr", mw_a[b0], 16'h0010);
      chk("R11 complete byte data", mw_d[b0], 8'h11);
   endtask

   task automatic t_mem_read;
      int b0;
      b0 = nmr;
      txb[0] = 8'h03; txb[1] = 8'hAB; txb[2] = 8'hFF;
      txb[3] = 8'h00; txb[4] = 8'h00; txb[5] = 8'h00;
      frame(6, 0);
      chk("R7 byte 0", rxb[3], fm(16'hABFF));
      chk("R7 byte 1 after carry", rxb[4], fm(16'hAC00));
      chk("R7 byte 2", rxb[5], fm(16'hAC01));
      chk("R7 read strobe count", nmr - b0, 4);
      chk("R7 first read addr", mr_a[b0], 16'hABFF);
      chk("R7 second read addr", mr_a[b0+1], 16'hAC00);
      chk("R6 no output enable in command byte of read", oe_op, 0);
   endtask

   task automatic t_comp;
      int b0, bm, br;
      cmd1(8'h06);
      b0 = ncw; bm = nmw;
      txb[0] = 8'h12; txb[1] = 8'hFE; txb[2] = 8'h01; txb[3] = 8'h02; txb[4] = 8'h03;
      frame(5, 0);
      chk("R9 register write count", ncw - b0, 3);
      chk("R9 register write addr 0", cw_a[b0], 16'h00FE);
      chk("R9 register write wraps", cw_a[b0+2], 16'h0000);
      chk("R9 register write data 2", cw_d[b0+2], 8'h03);
      chk("R12 no memory write on register command", nmw - bm, 0);
      chk("R3 latch cleared after 0x12", status, 8'h00);
      br = ncr;
      txb[0] = 8'h13; txb[1] = 8'hFF; txb[2] = 8'h00; txb[3] = 8'h00;
      frame(4, 0);
      chk("R9 register read byte 0", rxb[2], 8'h00);
      chk("R9 register read byte 1 wrapped", rxb[3], 8'hFF);
      chk("R9 register read addr wraps", cr_a[br+1], 16'h0000);
   endtask

   task automatic t_unknown;
      int a, b, c, d;
      cmd1(8'h06);
      a = nmw; b = nmr; c = ncw; d = ncr;
      txb[0] = 8'h77; txb[1] = 8'h55; txb[2] = 8'h66;
      frame(3, 0);
      chk("R10 unknown code keeps output off", oe_any, 0);
      chk("R10 unknown code makes no strobe", (nmw - a) + (nmr - b) + (ncw - c) + (ncr - d), 0);
      chk("R10 unknown code leaves status", status, 8'h02);
      chk("R10 output off after deselect", so_oe, 1'b0);
      cmd1(8'h04);
   endtask

   initial begin : p_watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   initial begin : p_main
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_set_clear();
      t_keep_latch();
      t_stat_write();
      t_mem_write();
      t_partial();
      t_mem_read();
      t_comp();
      t_unknown();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule